// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block splits a single input clock into instruction cycles of four input clocks each. Inside every instruction cycle exactly one of four phase strobes (Q1, Q2, Q3, Q4) is high per input clock. The strobes are clock enables in the input clock domain, not derived clocks. The phases pace a two-stage pipeline, so fetching the next instruction word overlaps executing the current one. The program counter advances in Q1. The fetch address is then held steady for the rest of the cycle. At the end of Q4 the word returned by a synchronous (one-cycle latency) program memory is loaded into the instruction register, and the execute stage uses it for the whole next cycle.

The block also produces a divided clock at a quarter of the input rate. It is high in Q1 and Q2 and low in Q3 and Q4. Addresses count bytes, and the counter moves by a fixed power-of-two step, so the low address bits are always zero. Parameters select the address and word widths, the step, the reset address and the no-operation word. Two further parameters choose how the phases and the divided clock are built. Decode, arithmetic and data storage are outside this block.

Top module: `qcyc_seq`

## Requirements
- R1: While reset is asserted and in the first input clock after release, `phase_q` is 4'b0001 (Q1), `clk_div` is 1, `pc_inc` is 1, `imem_addr` equals RESET_PC and `ir_word` equals NOP_WORD.
- R2: `phase_q` has exactly one bit high in every input clock. Bit 0 is Q1, bit 1 is Q2, bit 2 is Q3 and bit 3 is Q4. The sequence is Q1, Q2, Q3, Q4 and then Q1 again.
- R3: `clk_div` is 1 during Q1 and Q2 and 0 during Q3 and Q4, so its period is four input clocks.
- R4: `pc_inc` is high exactly during Q1, which is the clock whose closing edge advances the program counter by PC_STEP.
- R5: Number the instruction cycles from k = 0 after reset. During Q2 to Q4 of cycle k, `imem_addr` equals (RESET_PC + k*PC_STEP) mod 2^ADDR_W. During Q1 it keeps the value of the previous cycle, which is RESET_PC for k = 0.
- R6: `ir_word` changes only at the edge that ends Q4. Throughout cycle k >= 1 it holds the memory word at address RESET_PC + (k-1)*PC_STEP, so the instruction one step behind the current fetch address is being executed.
- R7: Throughout cycle 0, `ir_word` holds NOP_WORD, so the first execute cycle does nothing.
- R8: The low log2(PC_STEP) bits of `imem_addr` are always 0.
- R9: The fetch address wraps from the top of the ADDR_W-bit space to zero without stalling the phase sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | ADDR_W | Byte address to the synchronous program memory |
| imem_rdata | input | INSTR_W | Word read, valid one clock after its address |
| phase_q | output | 4 | One-hot phase strobes, bit 0 = Q1 ... bit 3 = Q4 |
| pc_inc | output | 1 | Program-counter advance strobe (Q1) |
| ir_word | output | INSTR_W | Instruction register contents for the execute stage |
| clk_div | output | 1 | Input clock divided by four, high in Q1 and Q2 |

## Verification
The bench builds two instances side by side. The first uses the defaults: a 21-bit address, 16-bit words, a step of 2, a binary phase counter and a registered divided clock. The second uses a 6-bit address, 12-bit words, a step of 4, reset address 56, a ring phase generator and a decoded divided clock. The second instance wraps the fetch address to zero inside its third instruction cycle, which brings R9 within a short run. Running both instances also exercises both generate variants and a non-zero reset address and no-operation word.

// File: rtl/qcyc_pkg.sv
package qcyc_pkg;

   localparam int unsigned PHASE_COUNT = 4;

   typedef enum logic [1:0] {
      PH_Q1 = 2'd0,
      PH_Q2 = 2'd1,
      PH_Q3 = 2'd2,
      PH_Q4 = 2'd3
   } phase_e;

   typedef logic [PHASE_COUNT-1:0] phase_vec_t;

   function automatic phase_vec_t ph_decode(input phase_e ph);
      phase_vec_t v;
      v = '0;
      v[ph] = 1'b1;
      return v;
   endfunction

   function automatic phase_e ph_next(input phase_e ph);
      return phase_e'(ph + 2'd1);
   endfunction

endpackage

// File: rtl/qcyc_phase_gen.sv
module qcyc_phase_gen
   import qcyc_pkg::*;
#(
   parameter bit RING_PHASE = 1'b0,
   parameter bit DIV_REG    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   output phase_vec_t phase_q,
   output logic       clk_div
);

   // Phase source: either a one-hot ring or a binary counter with a decoder.
   generate
      if (RING_PHASE) begin : g_ring
         phase_vec_t ring_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ring_r <= phase_vec_t'(1);
            else        ring_r <= {ring_r[PHASE_COUNT-2:0], ring_r[PHASE_COUNT-1]};
         end
         assign phase_q = ring_r;
      end else begin : g_cnt
         phase_e cnt_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_r <= PH_Q1;
            else        cnt_r <= ph_next(cnt_r);
         end
         always_comb phase_q = ph_decode(cnt_r);
      end
   endgenerate

   // Divided clock: a flop loaded with the level of the coming phase, or a direct decode.
   generate
      if (DIV_REG) begin : g_div_reg
         logic div_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) div_r <= 1'b1;
            else        div_r <= phase_q[PH_Q4] | phase_q[PH_Q1];
         end
         assign clk_div = div_r;
      end else begin : g_div_comb
         assign clk_div = phase_q[PH_Q1] | phase_q[PH_Q2];
      end
   endgenerate

   // R2: exactly one phase strobe high
   assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(phase_q) == 1);

   // R2: Q4 is followed by Q1
   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q[PH_Q4] |=> phase_q[PH_Q1]);

   // R2: Q1 is followed by Q2
   assert_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q[PH_Q1] |=> phase_q[PH_Q2]);

endmodule

// File: rtl/qcyc_fetch_ctr.sv
module qcyc_fetch_ctr #(
   parameter int unsigned         ADDR_W   = 21,
   parameter int unsigned         PC_STEP  = 2,
   parameter logic [ADDR_W-1:0]   RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [ADDR_W-1:0] fetch_addr
);

   localparam int unsigned ALIGN_W = $clog2(PC_STEP);
   localparam int unsigned HI_W    = ADDR_W - ALIGN_W;
   localparam logic [HI_W-1:0] RESET_HI = RESET_PC[ADDR_W-1:ALIGN_W];

   logic [HI_W-1:0] pc_hi;
   logic [HI_W-1:0] fa_hi;

   // The counter points one step ahead; the fetch register takes its old value in Q1.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_hi <= RESET_HI;
         fa_hi <= RESET_HI;
      end else if (adv) begin
         fa_hi <= pc_hi;
         pc_hi <= pc_hi + 1'b1;
      end
   end

   assign fetch_addr = {fa_hi, {ALIGN_W{1'b0}}};

   // R5: address held outside the advance phase
   assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(fetch_addr));

endmodule

// File: rtl/qcyc_ir_stage.sv
module qcyc_ir_stage #(
   parameter int unsigned        INSTR_W  = 16,
   parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap,
   input  logic [INSTR_W-1:0] rdata,
   output logic [INSTR_W-1:0] ir
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ir <= NOP_WORD;
      else if (cap) ir <= rdata;
   end

   // R6: instruction register moves only on the capture phase
   assert_ir_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(ir));

endmodule

// File: rtl/qcyc_seq.sv
module qcyc_seq
   import qcyc_pkg::*;
#(
   parameter int unsigned        ADDR_W     = 21,
   parameter int unsigned        INSTR_W    = 16,
   parameter int unsigned        PC_STEP    = 2,
   parameter logic [ADDR_W-1:0]  RESET_PC   = '0,
   parameter logic [INSTR_W-1:0] NOP_WORD   = '0,
   parameter bit                 RING_PHASE = 1'b0,
   parameter bit                 DIV_REG    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [ADDR_W-1:0]  imem_addr,
   input  logic [INSTR_W-1:0] imem_rdata,
   output logic [3:0]         phase_q,
   output logic               pc_inc,
   output logic [INSTR_W-1:0] ir_word,
   output logic               clk_div
);

   localparam int unsigned ALIGN_W = $clog2(PC_STEP);

   // Elaboration-time parameter checks
   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("qcyc_seq: ADDR_W must be at least 2");
      end
      if (INSTR_W < 1) begin : g_bad_instr_w
         $error("qcyc_seq: INSTR_W must be at least 1");
      end
      if (PC_STEP < 2 || (PC_STEP & (PC_STEP - 1)) != 0) begin : g_bad_step
         $error("qcyc_seq: PC_STEP must be a power of two, at least 2");
      end
      if (ALIGN_W >= ADDR_W) begin : g_bad_align
         $error("qcyc_seq: PC_STEP must be smaller than the address space");
      end
      if ((RESET_PC & ADDR_W'(PC_STEP - 1)) != '0) begin : g_bad_reset_pc
         $error("qcyc_seq: RESET_PC must be a multiple of PC_STEP");
      end
   endgenerate

   phase_vec_t ph;

   qcyc_phase_gen #(
      .RING_PHASE (RING_PHASE),
      .DIV_REG    (DIV_REG)
   ) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_q (ph),
      .clk_div (clk_div)
   );

   qcyc_fetch_ctr #(
      .ADDR_W   (ADDR_W),
      .PC_STEP  (PC_STEP),
      .RESET_PC (RESET_PC)
   ) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (ph[PH_Q1]),
      .fetch_addr (imem_addr)
   );

   qcyc_ir_stage #(
      .INSTR_W  (INSTR_W),
      .NOP_WORD (NOP_WORD)
   ) u_ir (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (ph[PH_Q4]),
      .rdata (imem_rdata),
      .ir    (ir_word)
   );

   assign phase_q = ph;
   assign pc_inc  = ph[PH_Q1];

   // R3: divided clock rises only into Q1
   assert_div_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_div) |-> phase_q[PH_Q1]);

   // R3: divided clock falls only into Q3
   assert_div_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_div) |-> phase_q[PH_Q3]);

   // R4: increment strobe is followed by Q2
   assert_inc_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pc_inc |=> (phase_q[PH_Q2] && !pc_inc));

   // R6: instruction register stays put from Q1 to Q3
   assert_ir_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q[PH_Q1] || phase_q[PH_Q2]) |=> $stable(ir_word));

endmodule

// File: tb/qcyc_seq_bench.sv
`timescale 1ns/1ps
module qcyc_seq_bench;

   localparam int AW_A = 21, IW_A = 16, ST_A = 2, RP_A = 0;
   localparam int AW_B = 6,  IW_B = 12, ST_B = 4, RP_B = 56;
   localparam logic [IW_A-1:0] NOP_A = 16'h0000;
   localparam logic [IW_B-1:0] NOP_B = 12'hFFE;

   // Vector: [13:10] phase, [9] clk_div, [8] pc_inc, [7:4] addr step index, [3:0] ir index (15 = NOP)
   localparam int NVEC = 12;
   localparam logic [13:0] VEC [NVEC] = '{
      14'b0001_1_1_0000_1111,
      14'b0010_1_0_0000_1111,
      14'b0100_0_0_0000_1111,
      14'b1000_0_0_0000_1111,
      14'b0001_1_1_0000_0000,
      14'b0010_1_0_0001_0000,
      14'b0100_0_0_0001_0000,
      14'b1000_0_0_0001_0000,
      14'b0001_1_1_0001_0001,
      14'b0010_1_0_0010_0001,
      14'b0100_0_0_0010_0001,
      14'b1000_0_0_0010_0001
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [AW_A-1:0] addr_a;
   logic [IW_A-1:0] rdata_a, ir_a;
   logic [3:0]      ph_a;
   logic            inc_a, div_a;
   logic [AW_B-1:0] addr_b;
   logic [IW_B-1:0] rdata_b, ir_b;
   logic [3:0]      ph_b;
   logic            inc_b, div_b;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   function automatic logic [IW_A-1:0] mem_a(input longint a);
      logic [AW_A-1:0] x;
      x = AW_A'(a);
      return {x[14:0], 1'b1} ^ 16'hA500;
   endfunction

   function automatic logic [IW_B-1:0] mem_b(input longint a);
      logic [AW_B-1:0] x;
      x = AW_B'(a);
      return {x, 6'b000001};
   endfunction

   always @(posedge clk) begin
      rdata_a <= mem_a(longint'(addr_a));
      rdata_b <= mem_b(longint'(addr_b));
   end

   qcyc_seq u_qcyc_seq (
      .clk (clk), .rst_n (rst_n), .imem_addr (addr_a), .imem_rdata (rdata_a),
      .phase_q (ph_a), .pc_inc (inc_a), .ir_word (ir_a), .clk_div (div_a)
   );

   qcyc_seq #(
      .ADDR_W (AW_B), .INSTR_W (IW_B), .PC_STEP (ST_B), .RESET_PC (AW_B'(RP_B)),
      .NOP_WORD (NOP_B), .RING_PHASE (1'b1), .DIV_REG (1'b0)
   ) u_qcyc_seq_alt (
      .clk (clk), .rst_n (rst_n), .imem_addr (addr_b), .imem_rdata (rdata_b),
      .phase_q (ph_b), .pc_inc (inc_b), .ir_word (ir_b), .clk_div (div_b)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic longint addr_at(input int idx, input int rp, input int st, input int aw);
      return (longint'(rp) + longint'(idx) * st) & ((longint'(1) << aw) - 1);
   endfunction

   // Expected fetch step index at clock t after release
   function automatic int fidx(input int t);
      int k = t / 4;
      if (t % 4 == 0) return (k == 0) ? 0 : k - 1;
      return k;
   endfunction

   task automatic check_formula(input int t);
      int k = t / 4;
      int p = t % 4;
      longint ea = addr_at(fidx(t), RP_A, ST_A, AW_A);
      longint eb = addr_at(fidx(t), RP_B, ST_B, AW_B);
      chk("R2 phase main", ph_a, longint'(1) << p);
      chk("R2 phase alt", ph_b, longint'(1) << p);
      chk("R3 div main", div_a, (p < 2) ? 1 : 0);
      chk("R3 div alt", div_b, (p < 2) ? 1 : 0);
      chk("R4 inc main", inc_a, (p == 0) ? 1 : 0);
      chk("R4 inc alt", inc_b, (p == 0) ? 1 : 0);
      chk("R5 addr main", addr_a, ea);
      chk("R5 addr alt", addr_b, eb);
      chk("R8 align main", addr_a & (ST_A - 1), 0);
      chk("R8 align alt", addr_b & (ST_B - 1), 0);
      if (k == 0) begin
         chk("R7 nop main", ir_a, NOP_A);
         chk("R7 nop alt", ir_b, NOP_B);
      end else begin
         chk("R6 ir main", ir_a, mem_a(addr_at(k - 1, RP_A, ST_A, AW_A)));
         chk("R6 ir alt", ir_b, mem_b(addr_at(k - 1, RP_B, ST_B, AW_B)));
      end
      if (k == 2 && p != 0) chk("R9 wrap alt", addr_b, 0);
   endtask

   task automatic release_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: values while reset is held
      chk("R1 reset phase", ph_a, 4'b0001);
      chk("R1 reset ir", ir_a, NOP_A);
      chk("R1 reset addr alt", addr_b, RP_B);
      release_reset();
      // Table walk over the first three instruction cycles
      for (int t = 0; t < NVEC; t++) begin
         logic [13:0] v;
         if (t > 0) @(negedge clk);
         v = VEC[t];
         if (t == 0) begin
            chk("R1 first phase", ph_a, 4'b0001);
            chk("R1 first div", div_a, 1);
            chk("R1 first addr", addr_a, RP_A);
         end
         chk("R2 tbl phase main", ph_a, v[13:10]);
         chk("R2 tbl phase alt", ph_b, v[13:10]);
         chk("R3 tbl div main", div_a, v[9]);
         chk("R3 tbl div alt", div_b, v[9]);
         chk("R4 tbl inc main", inc_a, v[8]);
         chk("R4 tbl inc alt", inc_b, v[8]);
         chk("R5 tbl addr main", addr_a, addr_at(int'(v[7:4]), RP_A, ST_A, AW_A));
         chk("R5 tbl addr alt", addr_b, addr_at(int'(v[7:4]), RP_B, ST_B, AW_B));
         if (v[3:0] == 4'hF) begin
            chk("R7 tbl nop main", ir_a, NOP_A);
            chk("R7 tbl nop alt", ir_b, NOP_B);
         end else begin
            chk("R6 tbl ir main", ir_a, mem_a(addr_at(int'(v[3:0]), RP_A, ST_A, AW_A)));
            chk("R6 tbl ir alt", ir_b, mem_b(addr_at(int'(v[3:0]), RP_B, ST_B, AW_B)));
         end
      end
      // Longer run: several alt wraps (R9) and continued overlap
      for (int t = NVEC; t < 160; t++) begin
         @(negedge clk);
         check_formula(t);
      end
      // Reset in the middle of a cycle, then restart
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 midrun phase main", ph_a, 4'b0001);
      chk("R1 midrun phase alt", ph_b, 4'b0001);
      chk("R1 midrun ir alt", ir_b, NOP_B);
      chk("R1 midrun addr main", addr_a, RP_A);
      chk("R1 midrun div alt", div_b, 1);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int t = 0; t < 24; t++) begin
         if (t > 0) @(negedge clk);
         check_formula(t);
      end
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule